// File: doc/BRIEF.md
# Host Command Decoder with Register Bank

This block sits behind a host link that delivers command packets as a stream of bytes with a valid/ready handshake. The first byte of each packet is a command code, and the code decides how many bytes follow and what they mean. The block decodes the packets into reads and writes of a bank of 32-bit registers. Register read replies go back on a separate byte stream, most significant byte first. Firmware-upload bytes, side-memory read requests and sample-data read requests leave the block as single-cycle strobes. The block does not service those requests itself.

The register bank holds a read-only status word. It reads as a fixed pattern with bit 0 clear. Once the correct unlock values are present in both key registers, bit 0 of the status word reads as one and the `unlocked` output rises. Register addresses travel as byte addresses, so a register with index i is addressed as i*4.

Top module: `hostcmd_regfile`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid`, `unlocked`, `fw_start`, `fw_valid`, `mem_req` and `smp_req` are all 0.
- R2: Code 4 (write) takes an address byte, a length byte and that many data bytes. With length 4, the value is assembled most significant byte first into the register at index address/4. Code 3 (read) takes an address byte and a length byte, and its reply is always 4 bytes on `out_data`, most significant byte first.
- R3: Index 2 is the status register and reads 0xA5A5A5A0 while locked. Writes to it are ignored.
- R4: Once index 16 holds 0x641381F6 and index 17 holds 0x00000000, and both have been written since reset, `unlocked` rises and stays high until reset, and status reads 0xA5A5A5A1. A wrong key value leaves the block locked.
- R5: A write packet whose length is not 4 still has its whole payload consumed, and the target register keeps its value.
- R6: An address with nonzero bits [1:0], or with an index of NUM_REGS (32) or more, is unmapped. A write to it changes no register, and a read of it returns 0.
- R7: A code byte that is not 1, 2, 3, 4, 5 or 7 is dropped, and the byte that follows is decoded as a new code.
- R8: Code 1 has no payload. It produces a one-cycle `fw_start` pulse in the cycle after the code byte is accepted.
- R9: Code 2 takes a length byte and then that many payload bytes. Each payload byte appears on `fw_data` with `fw_valid` in the cycle after it is accepted. A length above 250 has its payload consumed, but no `fw_valid` is produced.
- R10: Code 5 takes a high address byte, a low address byte and a length byte. It then pulses `mem_req` for one cycle, with `mem_addr` = {high, low} and `mem_len` = the length.
- R11: Code 7 takes one byte. It then pulses `smp_req` for one cycle, with `smp_sel` equal to that byte.
- R12: From the moment a read's length byte is accepted until its last reply byte is taken, `in_ready` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 8 | Command byte stream data |
| in_valid | input | 1 | Command byte present |
| in_ready | output | 1 | Block accepts a command byte |
| out_data | output | 8 | Reply byte |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Host takes the reply byte |
| fw_start | output | 1 | Firmware upload begins (pulse) |
| fw_valid | output | 1 | Firmware payload byte present (pulse per byte) |
| fw_data | output | 8 | Firmware payload byte |
| mem_req | output | 1 | Side-memory read request (pulse) |
| mem_addr | output | 16 | Side-memory address |
| mem_len | output | 8 | Side-memory byte count |
| smp_req | output | 1 | Sample-data read request (pulse) |
| smp_sel | output | 8 | Sample-data selector byte |
| unlocked | output | 1 | Key accepted, sticky until reset |

## Verification
The assertions watch the reply stream on every cycle: stable data under backpressure, and the input kept stalled while a reply is pending. They also check that `unlocked` never falls once it has risen, that a payload or request strobe only follows an accepted byte, and that two request strobes never appear together. Register contents, the big-endian order of a reply, the status pattern, and whether a short write, an unmapped access or an unknown code left the bank untouched can only be seen by reading the bank back in the directed scenarios.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
  localparam logic [7:0] CMD_FW_BEGIN = 8'd1;
  localparam logic [7:0] CMD_FW_CHUNK = 8'd2;
  localparam logic [7:0] CMD_RD_REG   = 8'd3;
  localparam logic [7:0] CMD_WR_REG   = 8'd4;
  localparam logic [7:0] CMD_RD_MEM   = 8'd5;
  localparam logic [7:0] CMD_SAMPLE   = 8'd7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR_HI,
    S_ADDR,
    S_LEN,
    S_DATA,
    S_REPLY
  } parse_state_t;
endpackage

// File: rtl/hcr_parser.sv
module hcr_parser
  import hcr_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int MAX_CHUNK = 250,
  parameter int WR_BYTES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [7:0]        in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              tx_done,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [7:0]        reg_addr,
  output logic [DATA_W-1:0] wdata,
  output logic              fw_start,
  output logic              fw_valid,
  output logic [7:0]        fw_data,
  output logic              mem_req,
  output logic [15:0]       mem_addr,
  output logic [7:0]        mem_len,
  output logic              smp_req,
  output logic [7:0]        smp_sel
);
  parse_state_t state;
  logic [7:0] cmd;
  logic [7:0] addr_hi;
  logic [7:0] len;
  logic [7:0] remain;
  logic       chunk_ok;
  logic       acc;

  assign in_ready = (state != S_REPLY);
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cmd      <= '0;
      addr_hi  <= '0;
      len      <= '0;
      remain   <= '0;
      chunk_ok <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      reg_addr <= '0;
      wdata    <= '0;
      fw_start <= 1'b0;
      fw_valid <= 1'b0;
      fw_data  <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      mem_len  <= '0;
      smp_req  <= 1'b0;
      smp_sel  <= '0;
    end else begin
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      fw_start <= 1'b0;
      fw_valid <= 1'b0;
      mem_req  <= 1'b0;
      smp_req  <= 1'b0;
      if (state == S_REPLY) begin
        if (tx_done) state <= S_IDLE;
      end else if (acc) begin
        case (state)
          S_IDLE: begin
            cmd <= in_data;
            case (in_data)
              CMD_FW_BEGIN: fw_start <= 1'b1;
              CMD_FW_CHUNK: state <= S_LEN;
              CMD_RD_REG, CMD_WR_REG, CMD_SAMPLE: state <= S_ADDR;
              CMD_RD_MEM: state <= S_ADDR_HI;
              default: state <= S_IDLE;
            endcase
          end
          S_ADDR_HI: begin
            addr_hi <= in_data;
            state   <= S_ADDR;
          end
          S_ADDR: begin
            reg_addr <= in_data;
            if (cmd == CMD_SAMPLE) begin
              smp_req <= 1'b1;
              smp_sel <= in_data;
              state   <= S_IDLE;
            end else begin
              state <= S_LEN;
            end
          end
          S_LEN: begin
            len    <= in_data;
            remain <= in_data;
            case (cmd)
              CMD_RD_REG: begin
                rd_stb <= 1'b1;
                state  <= S_REPLY;
              end
              CMD_RD_MEM: begin
                mem_req  <= 1'b1;
                mem_addr <= {addr_hi, reg_addr};
                mem_len  <= in_data;
                state    <= S_IDLE;
              end
              default: begin
                chunk_ok <= (int'(in_data) <= MAX_CHUNK);
                state    <= (in_data == 8'd0) ? S_IDLE : S_DATA;
              end
            endcase
          end
          S_DATA: begin
            remain <= remain - 8'd1;
            if (cmd == CMD_FW_CHUNK) begin
              fw_valid <= chunk_ok;
              fw_data  <= in_data;
            end else begin
              wdata <= {wdata[DATA_W-9:0], in_data};
            end
            if (remain == 8'd1) begin
              state <= S_IDLE;
              if (cmd == CMD_WR_REG && int'(len) == WR_BYTES) wr_stb <= 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/hcr_regbank.sv
module hcr_regbank #(
  parameter int          DATA_W     = 32,
  parameter int          NUM_REGS   = 32,
  parameter int          STATUS_IDX = 2,
  parameter int          KEY0_IDX   = 16,
  parameter int          KEY1_IDX   = 17,
  parameter logic [31:0] KEY0_VAL   = 32'h641381F6,
  parameter logic [31:0] KEY1_VAL   = 32'h00000000,
  parameter logic [31:0] STATUS_PAT = 32'hA5A5A5A0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [7:0]        reg_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic              unlocked
);
  localparam int IDX_W = 6;
  localparam int MEM_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic [IDX_W-1:0]  idx;
  logic [MEM_W-1:0]  midx;
  logic              mapped;
  logic              wr_ok;
  logic [DATA_W-1:0] rd_raw;
  logic              rd_status;
  logic              rd_zero;
  logic [DATA_W-1:0] key0_q, key1_q;
  logic              key0_seen, key1_seen;

  assign idx    = reg_addr[7:2];
  assign midx   = idx[MEM_W-1:0];
  assign mapped = (reg_addr[1:0] == 2'b00) && (int'(idx) < NUM_REGS);
  assign wr_ok  = wr_stb && mapped && (int'(idx) != STATUS_IDX);

  // Storage without reset so that it maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[midx] <= wdata;
    if (rd_stb) rd_raw <= mem[midx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid    <= 1'b0;
      rd_status <= 1'b0;
      rd_zero   <= 1'b0;
    end else begin
      rvalid <= rd_stb;
      if (rd_stb) begin
        rd_status <= mapped && (int'(idx) == STATUS_IDX);
        rd_zero   <= !mapped;
      end
    end
  end

  always_comb begin
    if (rd_zero)        rdata = '0;
    else if (rd_status) rdata = {STATUS_PAT[DATA_W-1:1], unlocked};
    else                rdata = rd_raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      key0_q    <= '0;
      key1_q    <= '0;
      key0_seen <= 1'b0;
      key1_seen <= 1'b0;
      unlocked  <= 1'b0;
    end else begin
      if (wr_ok && int'(idx) == KEY0_IDX) begin
        key0_q    <= wdata;
        key0_seen <= 1'b1;
      end
      if (wr_ok && int'(idx) == KEY1_IDX) begin
        key1_q    <= wdata;
        key1_seen <= 1'b1;
      end
      unlocked <= unlocked || (key0_seen && key1_seen &&
                               key0_q == KEY0_VAL && key1_q == KEY1_VAL);
    end
  end
endmodule

// File: rtl/hcr_replyser.sv
module hcr_replyser #(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int CNT_W  = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              tx_done
);
  logic [DATA_W-1:0] sreg;
  logic [CNT_W-1:0]  cnt;

  assign out_valid = (cnt != '0);
  assign out_data  = sreg[DATA_W-1:DATA_W-8];
  assign tx_done   = (cnt == CNT_W'(1)) && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg <= '0;
      cnt  <= '0;
    end else if (load) begin
      sreg <= load_data;
      cnt  <= CNT_W'(NBYTES);
    end else if (out_valid && out_ready) begin
      sreg <= {sreg[DATA_W-9:0], 8'h00};
      cnt  <= cnt - CNT_W'(1);
    end
  end
endmodule

// File: rtl/hostcmd_regfile.sv
module hostcmd_regfile #(
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 32,
  parameter int MAX_CHUNK = 250
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  out_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        fw_start,
  output logic        fw_valid,
  output logic [7:0]  fw_data,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_len,
  output logic        smp_req,
  output logic [7:0]  smp_sel,
  output logic        unlocked
);
  logic              rd_stb, wr_stb, rvalid, tx_done;
  logic [7:0]        reg_addr;
  logic [DATA_W-1:0] wdata, rdata;

  hcr_parser #(.DATA_W(DATA_W), .MAX_CHUNK(MAX_CHUNK)) u_parser (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .tx_done(tx_done), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .reg_addr(reg_addr), .wdata(wdata), .fw_start(fw_start),
    .fw_valid(fw_valid), .fw_data(fw_data), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_len(mem_len), .smp_req(smp_req),
    .smp_sel(smp_sel)
  );

  hcr_regbank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .reg_addr(reg_addr), .wdata(wdata), .rvalid(rvalid), .rdata(rdata),
    .unlocked(unlocked)
  );

  hcr_replyser #(.DATA_W(DATA_W)) u_reply (
    .clk(clk), .rst(rst), .load(rvalid), .load_data(rdata),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .tx_done(tx_done)
  );
endmodule

// File: rtl/hcr_checker.sv
module hcr_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] out_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic       fw_start,
  input logic       fw_valid,
  input logic       mem_req,
  input logic       smp_req,
  input logic       unlocked
);
  assert_reply_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_input_stall_R12: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  assert_unlock_sticky_R4: assert property (@(posedge clk) disable iff (rst)
    unlocked |=> unlocked);

  assert_fw_byte_follows_accept_R9: assert property (@(posedge clk) disable iff (rst)
    fw_valid |-> $past(in_valid && in_ready));

  assert_mem_req_follows_accept_R10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> $past(in_valid && in_ready));

  assert_smp_req_follows_accept_R11: assert property (@(posedge clk) disable iff (rst)
    smp_req |-> $past(in_valid && in_ready));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fw_start, fw_valid, mem_req, smp_req}));
endmodule

bind hostcmd_regfile hcr_checker i_hcr_checker (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
  .fw_start(fw_start), .fw_valid(fw_valid), .mem_req(mem_req),
  .smp_req(smp_req), .unlocked(unlocked)
);

// File: tb/test_hostcmd_regfile.sv
`timescale 1ns/1ps
module test_hostcmd_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        fw_start, fw_valid, mem_req, smp_req, unlocked;
  logic [7:0]  fw_data, mem_len, smp_sel;
  logic [15:0] mem_addr;

  int checks = 0;
  int errors = 0;
  int fw_starts = 0;
  int fw_n = 0;
  logic [7:0] fw_buf [8];
  int mem_n = 0;
  logic [15:0] mem_a_seen;
  logic [7:0]  mem_l_seen;
  int smp_n = 0;
  logic [7:0] smp_seen;

  always #5 clk = ~clk;

  hostcmd_regfile i_hostcmd_regfile (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid),
    .out_ready(out_ready), .fw_start(fw_start), .fw_valid(fw_valid),
    .fw_data(fw_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_len(mem_len), .smp_req(smp_req), .smp_sel(smp_sel),
    .unlocked(unlocked)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (fw_start) fw_starts++;
      if (fw_valid) begin
        if (fw_n < 8) fw_buf[fw_n] = fw_data;
        fw_n++;
      end
      if (mem_req) begin mem_n++; mem_a_seen = mem_addr; mem_l_seen = mem_len; end
      if (smp_req) begin smp_n++; smp_seen = smp_sel; end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic collect_reply(output logic [31:0] v);
    v = '0;
    out_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      while (!out_valid) @(negedge clk);
      v = {v[23:0], out_data};
      @(negedge clk);
    end
  endtask

  task automatic write_reg(input logic [7:0] addr, input logic [31:0] v);
    send_byte(8'd4); send_byte(addr); send_byte(8'd4);
    for (int k = 3; k >= 0; k--) send_byte(v[k*8 +: 8]);
  endtask

  task automatic read_reg(input logic [7:0] addr, output logic [31:0] v);
    send_byte(8'd3); send_byte(addr); send_byte(8'd4);
    collect_reply(v);
  endtask

  task automatic t_reset;
    check("R1 in_ready", {31'b0, in_ready}, 32'd1);
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 unlocked", {31'b0, unlocked}, 32'd0);
    check("R1 strobes", {28'b0, fw_start, fw_valid, mem_req, smp_req}, 32'd0);
  endtask

  task automatic t_write_read;
    logic [31:0] v;
    write_reg(8'h14, 32'h12345678);
    write_reg(8'h7C, 32'hCAFEF00D);
    read_reg(8'h14, v); check("R2 reg5", v, 32'h12345678);
    read_reg(8'h7C, v); check("R2 reg31", v, 32'hCAFEF00D);
  endtask

  task automatic t_status;
    logic [31:0] v;
    read_reg(8'h08, v); check("R3 status locked", v, 32'hA5A5A5A0);
    write_reg(8'h08, 32'h00000000);
    read_reg(8'h08, v); check("R3 status write ignored", v, 32'hA5A5A5A0);
  endtask

  task automatic t_unlock;
    logic [31:0] v;
    write_reg(8'h40, 32'h11111111);
    write_reg(8'h44, 32'h00000000);
    repeat (3) @(negedge clk);
    check("R4 wrong key locked", {31'b0, unlocked}, 32'd0);
    read_reg(8'h08, v); check("R4 wrong key status", v, 32'hA5A5A5A0);
    write_reg(8'h40, 32'h641381F6);
    repeat (3) @(negedge clk);
    check("R4 unlocked", {31'b0, unlocked}, 32'd1);
    read_reg(8'h08, v); check("R4 status unlocked", v, 32'hA5A5A5A1);
  endtask

  task automatic t_bad_len;
    logic [31:0] v;
    send_byte(8'd4); send_byte(8'h14); send_byte(8'd3);
    send_byte(8'hAA); send_byte(8'hBB); send_byte(8'hCC);
    read_reg(8'h14, v); check("R5 len3 unchanged", v, 32'h12345678);
    send_byte(8'd4); send_byte(8'h14); send_byte(8'd5);
    for (int k = 0; k < 5; k++) send_byte(8'h99);
    read_reg(8'h14, v); check("R5 len5 unchanged", v, 32'h12345678);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    write_reg(8'h94, 32'hDEADBEEF);
    read_reg(8'h14, v); check("R6 no alias write", v, 32'h12345678);
    read_reg(8'h94, v); check("R6 high index reads 0", v, 32'h0);
    write_reg(8'h15, 32'h55555555);
    read_reg(8'h14, v); check("R6 misaligned write ignored", v, 32'h12345678);
    read_reg(8'h15, v); check("R6 misaligned reads 0", v, 32'h0);
  endtask

  task automatic t_unknown;
    logic [31:0] v;
    send_byte(8'h09);
    send_byte(8'h00);
    read_reg(8'h7C, v); check("R7 resync after unknown", v, 32'hCAFEF00D);
  endtask

  task automatic t_fw;
    int s0;
    s0 = fw_starts;
    send_byte(8'd1);
    @(negedge clk);
    check("R8 fw_start pulses", fw_starts - s0, 32'd1);
    fw_n = 0;
    send_byte(8'd2); send_byte(8'd3);
    send_byte(8'hA1); send_byte(8'hB2); send_byte(8'hC3);
    @(negedge clk);
    check("R9 chunk count", fw_n, 32'd3);
    check("R9 chunk bytes", {8'h0, fw_buf[0], fw_buf[1], fw_buf[2]}, 32'h00A1B2C3);
    fw_n = 0;
    send_byte(8'd2); send_byte(8'd251);
    for (int k = 0; k < 251; k++) send_byte(8'h5A);
    @(negedge clk);
    check("R9 oversize chunk suppressed", fw_n, 32'd0);
  endtask

  task automatic t_mem_smp;
    send_byte(8'd5); send_byte(8'h0F); send_byte(8'hA0); send_byte(8'h08);
    @(negedge clk);
    check("R10 mem_req count", mem_n, 32'd1);
    check("R10 mem_addr/len", {8'h0, mem_a_seen, mem_l_seen}, 32'h000FA008);
    send_byte(8'd7); send_byte(8'h03);
    @(negedge clk);
    check("R11 smp_req count", smp_n, 32'd1);
    check("R11 smp_sel", {24'h0, smp_seen}, 32'h3);
  endtask

  task automatic t_backpressure;
    logic [31:0] v;
    logic [7:0]  first;
    out_ready = 1'b0;
    send_byte(8'd3); send_byte(8'h14); send_byte(8'd4);
    while (!out_valid) @(negedge clk);
    first = out_data;
    repeat (5) @(negedge clk);
    check("R12 data held", {24'h0, out_data}, {24'h0, first});
    check("R12 valid held", {31'b0, out_valid}, 32'd1);
    check("R12 input stalled", {31'b0, in_ready}, 32'd0);
    collect_reply(v);
    check("R12 reply after stall", v, 32'h12345678);
    @(negedge clk);
    check("R12 input resumes", {31'b0, in_ready}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_status();
    t_bad_len();
    t_unmapped();
    t_unknown();
    t_fw();
    t_mem_smp();
    t_backpressure();
    t_unlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule